// File: doc/BRIEF.md
# Request/Acknowledge Bus Clock-Domain Crossing

This block carries one multi-bit word at a time from a source clock domain into an unrelated destination clock domain. Only two control wires cross between the domains, a request going one way and an acknowledge coming back. Each of them passes through its own chain of back-to-back flip-flops. The data word is never synchronized bit by bit. The sender registers the word onto a crossing bus and holds it unchanged until the handshake closes. The receiver samples that bus only after it has seen the synchronized request.

On the source side a word is offered with a valid/ready pair. On the destination side each delivered word appears with a one-cycle valid pulse. The parameter `TWO_PHASE` picks the signalling style. With 0 the handshake is level based: request high, acknowledge high, request low, acknowledge low. With 1 it is toggle based: each transfer flips the request once and is answered by one flip of the acknowledge. In that mode a single state bit on each side is cleared by that side's reset. `SYNC_STAGES` sets the depth of both synchronizer chains and must be at least 2.

Top module: `bus_handshake_cdc`

## Requirements
- R1: A word accepted on a source clock edge where `src_valid` and `src_ready` are both high is delivered on `dst_data` unchanged. Words are delivered in acceptance order, and each accepted word is delivered exactly once.
- R2: `src_ready` is low in the source cycle after an acceptance. It stays low until the handshake for that word has completed. It is high only when no accepted word is still undelivered.
- R3: `dst_valid` is high for exactly one destination cycle per delivered word, and never on two consecutive destination cycles.
- R4: `src_data` values present while no acceptance occurs, whether `src_valid` is low or `src_ready` is low, have no effect on any delivered word.
- R5: With `TWO_PHASE`=0, the request rises only after the word is on the crossing bus. The acknowledge rises only in the destination cycle after capture. The sender lowers the request only after it sees the acknowledge high. It returns to idle only after it sees the acknowledge low. Every offered word is delivered.
- R6: With `TWO_PHASE`=1, each transfer changes the request level exactly once and the acknowledge level exactly once. The acknowledge changes only in the destination cycle after capture. Every offered word is delivered.
- R7: Once both resets are released, `src_ready` is 1, `dst_valid` is 0 and `dst_data` is 0. The request, the acknowledge and both toggle-state bits are 0.
- R8: With two synchronizer stages and a destination clock at least 0.7 times the source clock, `src_ready` returns high within 40 source cycles of an acceptance.
- R9: The crossing data bus changes only on an acceptance edge. It stays stable while `src_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_valid | input | 1 | Source offers a word |
| src_ready | output | 1 | Sender idle; a word offered now is taken |
| src_data | input | DATA_W | Word offered by the source |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_valid | output | 1 | One-cycle pulse marking a delivered word |
| dst_data | output | DATA_W | Last delivered word, held until the next delivery |

## Verification
A sender stuck outside idle shows up as `src_ready` staying low. The per-transfer 40-cycle bound reports it within one transfer. A receiver that re-arms wrongly shows up as a second `dst_valid` pulse, or as a duplicate word at the head of the reference queue, within a few destination cycles. A bus register loaded at the wrong time delivers a word that differs from the reference queue. This is visible on the very next pulse, because the bench drives changing values on `src_data` whenever no acceptance occurs.

// File: rtl/hs_cdc_pkg.sv
package hs_cdc_pkg;

    typedef enum logic [1:0] {
        SND_IDLE  = 2'd0,
        SND_LOAD  = 2'd1,
        SND_WAIT  = 2'd2,
        SND_DRAIN = 2'd3
    } snd_state_e;

    typedef enum logic [1:0] {
        RCV_IDLE = 2'd0,
        RCV_CAPT = 2'd1,
        RCV_HOLD = 2'd2
    } rcv_state_e;

    // Level the request takes when a new transfer is announced.
    function automatic logic req_launch(input logic toggle_mode, input logic cur);
        return toggle_mode ? ~cur : 1'b1;
    endfunction

    // Receiver view: a new word is waiting.
    function automatic logic req_pending(input logic toggle_mode, input logic req_lvl,
                                         input logic ack_lvl);
        return toggle_mode ? (req_lvl != ack_lvl) : req_lvl;
    endfunction

    // Sender view: the receiver has answered the current request.
    function automatic logic ack_answered(input logic toggle_mode, input logic req_lvl,
                                          input logic ack_lvl);
        return toggle_mode ? (ack_lvl == req_lvl) : ack_lvl;
    endfunction

endpackage

// File: rtl/hs_sync_chain.sv
module hs_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES < 2) begin : g_bad_depth
            $error("hs_sync_chain: STAGES must be at least 2");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_sender.sv
module hs_sender
    import hs_cdc_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter bit TWO_PHASE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              ack_async,
    output logic              req_out,
    output logic [DATA_W-1:0] bus_out
);
    snd_state_e        state;
    logic              ack_s;
    logic              req_q;
    logic [DATA_W-1:0] bus_q;

    hs_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (ack_async),
        .q   (ack_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SND_IDLE;
            req_q <= 1'b0;
            bus_q <= '0;
        end else begin
            unique case (state)
                SND_IDLE: begin
                    if (in_valid) begin
                        bus_q <= in_data;
                        state <= SND_LOAD;
                    end
                end
                SND_LOAD: begin
                    req_q <= req_launch(TWO_PHASE, req_q);
                    state <= SND_WAIT;
                end
                SND_WAIT: begin
                    if (ack_answered(TWO_PHASE, req_q, ack_s)) begin
                        if (TWO_PHASE) begin
                            state <= SND_IDLE;
                        end else begin
                            req_q <= 1'b0;
                            state <= SND_DRAIN;
                        end
                    end
                end
                SND_DRAIN: begin
                    if (!ack_s) state <= SND_IDLE;
                end
                default: state <= SND_IDLE;
            endcase
        end
    end

    assign in_ready = (state == SND_IDLE);
    assign req_out  = req_q;
    assign bus_out  = bus_q;
endmodule

// File: rtl/hs_receiver.sv
module hs_receiver
    import hs_cdc_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter bit TWO_PHASE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_async,
    input  logic [DATA_W-1:0] bus_in,
    output logic              ack_out,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    rcv_state_e        state;
    logic              req_s;
    logic              ack_q;
    logic              valid_q;
    logic [DATA_W-1:0] data_q;

    hs_sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_async),
        .q   (req_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RCV_IDLE;
            ack_q   <= 1'b0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= 1'b0;
            unique case (state)
                RCV_IDLE: begin
                    if (req_pending(TWO_PHASE, req_s, ack_q)) begin
                        data_q  <= bus_in;
                        valid_q <= 1'b1;
                        state   <= RCV_CAPT;
                    end
                end
                RCV_CAPT: begin
                    ack_q <= TWO_PHASE ? ~ack_q : 1'b1;
                    state <= TWO_PHASE ? RCV_IDLE : RCV_HOLD;
                end
                RCV_HOLD: begin
                    if (!req_s) begin
                        ack_q <= 1'b0;
                        state <= RCV_IDLE;
                    end
                end
                default: state <= RCV_IDLE;
            endcase
        end
    end

    assign ack_out   = ack_q;
    assign out_valid = valid_q;
    assign out_data  = data_q;
endmodule

// File: rtl/bus_handshake_cdc.sv
module bus_handshake_cdc #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter bit TWO_PHASE   = 1'b0
) (
    input  logic              src_clk,
    input  logic              src_rst,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    input  logic              dst_clk,
    input  logic              dst_rst,
    output logic              dst_valid,
    output logic [DATA_W-1:0] dst_data
);
    logic              req_w;
    logic              ack_w;
    logic [DATA_W-1:0] xbus_w;

    hs_sender #(
        .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .TWO_PHASE(TWO_PHASE)
    ) u_sender (
        .clk       (src_clk),
        .rst       (src_rst),
        .in_valid  (src_valid),
        .in_ready  (src_ready),
        .in_data   (src_data),
        .ack_async (ack_w),
        .req_out   (req_w),
        .bus_out   (xbus_w)
    );

    hs_receiver #(
        .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .TWO_PHASE(TWO_PHASE)
    ) u_receiver (
        .clk       (dst_clk),
        .rst       (dst_rst),
        .req_async (req_w),
        .bus_in    (xbus_w),
        .ack_out   (ack_w),
        .out_valid (dst_valid),
        .out_data  (dst_data)
    );
endmodule

// File: rtl/bus_handshake_cdc_chk.sv
module bus_handshake_cdc_chk #(
    parameter int DATA_W    = 16,
    parameter bit TWO_PHASE = 1'b0
) (
    input logic              src_clk,
    input logic              src_rst,
    input logic              src_valid,
    input logic              src_ready,
    input logic [DATA_W-1:0] src_data,
    input logic              dst_clk,
    input logic              dst_rst,
    input logic              dst_valid,
    input logic              req_w,
    input logic              ack_w,
    input logic [DATA_W-1:0] xbus_w
);
    AST_BUS_LOADS_WORD: assert property (@(posedge src_clk) disable iff (src_rst)
        src_valid && src_ready |=> xbus_w == $past(src_data)); // R1

    AST_READY_DROPS: assert property (@(posedge src_clk) disable iff (src_rst)
        src_valid && src_ready |=> !src_ready); // R2

    AST_BUS_STABLE: assert property (@(posedge src_clk) disable iff (src_rst)
        !src_ready |=> $stable(xbus_w)); // R9

    AST_REQ_AFTER_LOAD: assert property (@(posedge src_clk) disable iff (src_rst)
        (req_w != $past(req_w)) |-> (!src_ready && $past(!src_ready))); // R5

    AST_VALID_PULSE: assert property (@(posedge dst_clk) disable iff (dst_rst)
        dst_valid |=> !dst_valid); // R3

    AST_ACK_AFTER_CAPTURE: assert property (@(posedge dst_clk) disable iff (dst_rst)
        (TWO_PHASE ? (ack_w != $past(ack_w)) : $rose(ack_w)) |-> $past(dst_valid)); // R6
endmodule

bind bus_handshake_cdc bus_handshake_cdc_chk #(
    .DATA_W(DATA_W), .TWO_PHASE(TWO_PHASE)
) u_chk (
    .src_clk   (src_clk),
    .src_rst   (src_rst),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .src_data  (src_data),
    .dst_clk   (dst_clk),
    .dst_rst   (dst_rst),
    .dst_valid (dst_valid),
    .req_w     (req_w),
    .ack_w     (ack_w),
    .xbus_w    (xbus_w)
);

// File: tb/bus_handshake_cdc_bench.sv
module bus_handshake_cdc_bench;
    localparam int W      = 16;
    localparam int NXFER  = 24;
    localparam int BOUND  = 40;

    logic src_clk = 1'b0;
    logic dst_clk = 1'b0;
    logic src_rst = 1'b1;
    logic dst_rst = 1'b1;
    int   n_cmp   = 0;
    int   n_bad   = 0;
    logic done [2];

    always #10 src_clk = ~src_clk;   // 50 MHz
    always #13.5 dst_clk = ~dst_clk;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", rq, act, exp, $time);
        end
    endtask

    for (genvar L = 0; L < 2; L++) begin : lane
        logic          v;
        logic          rdy;
        logic [W-1:0]  d;
        logic          dv;
        logic [W-1:0]  dd;
        logic [W-1:0]  q[$];
        int            pushed = 0;
        int            popped = 0;
        logic          prev_dv = 1'b0;
        string         mode_tag;

        bus_handshake_cdc #(.DATA_W(W), .SYNC_STAGES(2), .TWO_PHASE(L == 1))
        u_bus_handshake_cdc (
            .src_clk(src_clk), .src_rst(src_rst), .src_valid(v), .src_ready(rdy),
            .src_data(d), .dst_clk(dst_clk), .dst_rst(dst_rst),
            .dst_valid(dv), .dst_data(dd)
        );

        // Source driver and reference producer
        initial begin
            mode_tag = (L == 1) ? "R6" : "R5";
            done[L] = 1'b0;
            v = 1'b0;
            d = '0;
            wait (!src_rst && !dst_rst);
            @(negedge src_clk);
            chk(rdy == 1'b1, "R7", int'(rdy), 1);
            chk(dv == 1'b0, "R7", int'(dv), 0);
            chk(dd == '0, "R7", int'(dd), 0);
            for (int n = 0; n < NXFER; n++) begin
                logic [W-1:0] word;
                int busy;
                word = W'((n * 16'h3B1 + L * 16'h1000) ^ 16'hA5A5);
                for (int g = 0; g < (n % 4); g++) begin
                    d = ~word;               // R4: no valid, must be ignored
                    @(negedge src_clk);
                end
                v = 1'b1;
                d = word;
                while (!rdy) @(negedge src_clk);
                @(posedge src_clk);
                q.push_back(word);
                pushed++;
                @(negedge src_clk);
                if (n % 2 == 0) v = 1'b0;    // odd items keep valid high while busy
                d = word ^ 16'h0F0F;          // R4: changes while busy
                chk(rdy == 1'b0, "R2", int'(rdy), 0);
                busy = 1;
                while (!rdy && busy < 60) begin
                    d = d + 16'h1111;
                    @(negedge src_clk);
                    busy++;
                end
                v = 1'b0;
                chk(busy <= BOUND, "R8", busy, BOUND);
            end
            repeat (20) @(negedge src_clk);
            chk(popped == NXFER, mode_tag, popped, NXFER);
            done[L] = 1'b1;
        end

        // R2: ready may be high only with nothing outstanding
        always @(negedge src_clk) begin
            if (!src_rst && !dst_rst && rdy)
                chk(pushed == popped, "R2", pushed - popped, 0);
        end

        // Destination reference comparison
        always @(negedge dst_clk) begin
            if (!dst_rst) begin
                chk(!(dv && prev_dv), "R3", int'(prev_dv), 0);
                if (dv) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R1", int'(dd), 0);
                    end else begin
                        logic [W-1:0] exp_w;
                        exp_w = q.pop_front();
                        chk(dd == exp_w, "R1", int'(dd), int'(exp_w));
                        chk(dd == exp_w, "R4", int'(dd), int'(exp_w));
                    end
                    popped++;
                end
                prev_dv = dv;
            end
        end
    end

    initial begin
        repeat (5) @(posedge src_clk);
        src_rst = 1'b0;
    end

    initial begin
        repeat (4) @(posedge dst_clk);
        dst_rst = 1'b0;
    end

    initial begin
        wait (done[0] === 1'b1 && done[1] === 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge src_clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule